// File: doc/BRIEF.md
# RMII Bridge with Diagnostic Paths

This block joins a MAC that speaks a 4-bit nibble interface to a PHY that speaks the 2-bit reduced media-independent interface (RMII). Everything runs from a single 50 MHz reference clock. The bridge produces two clock-enable pulse trains in that domain. The RMII-side sampling enable runs at 50 MHz for 100 Mbps and at 5 MHz for 10 Mbps. The MAC-side nibble enable runs at half the RMII rate, which gives 25 MHz and 2.5 MHz. Each MAC nibble goes out as two dibits, low dibit first. Received dibit pairs are put back together into nibbles in the same order. The RMII carrier-sense/data-valid line is split into separate carrier-sense and data-valid outputs on the MAC side.

RMII operation is effective only when the MII-mode control bit and both pin-function select bits are all set. In every other case the bridge forwards a plain 4-bit MII PHY interface, one register stage per signal, and holds the RMII outputs at zero.

There are two diagnostic paths. Loopback sends the MAC's transmit nibbles through the serialiser and the assembler and back to the MAC receive outputs. Echo hands RMII receive data to the MAC and also retransmits it on the RMII transmit pins. Each path works only when its qualifying conditions hold. If both paths are requested, loopback wins and a conflict flag is raised.

Top module: `rmii_bridge`

## Requirements
- R1: `rmii_active` equals `cfg_mii_mode & cfg_pin_sel[1] & cfg_pin_sel[0]`, registered, so it shows the value of the previous cycle. The data paths use the same condition on the current cycle's inputs.
- R2: With `cfg_speed_10`=0, `rmii_smp_en` is high on every cycle. `mac_clk_en` is high on every second cycle, and its first pulse comes at the second clock edge after reset.
- R3: With `cfg_speed_10`=1, `rmii_smp_en` pulses one cycle in 10 and `mac_clk_en` pulses one cycle in 20. Every `mac_clk_en` pulse coincides with an `rmii_smp_en` pulse.
- R4: A transmit nibble is captured at the RMII tick that follows a MAC tick. `rmii_txd` takes `mac_txd[1:0]` and `rmii_tx_en` takes `mac_tx_en`. At the next RMII tick, `rmii_txd` takes the captured `mac_txd[3:2]`.
- R5: While carrier/data-valid is high and the receiver is armed, the first dibit sampled is held as bits [1:0]. The second dibit completes the nibble `{second, first}` on `mac_rxd`, and `mac_rx_dv` goes high at the same moment.
- R6: After reset, and after any period with RMII off, the receiver delivers no data until it has sampled carrier/data-valid low at least once.
- R7: At each RMII tick, `mac_crs` takes the sampled carrier/data-valid. A low sample clears `mac_rx_dv` and restarts the dibit alignment.
- R8: Loopback is effective when RMII is on, `cfg_rmii_loop`=1, `cfg_mac_loop`=0 and `cfg_full_duplex`=1. The receiver then takes its dibits and carrier from its own transmit registers, and `rmii_rxd`/`rmii_crs_dv` are ignored.
- R9: Echo is effective when RMII is on, `cfg_rmii_echo`=1, `cfg_rmii_loop`=0 and `cfg_mac_loop`=0. At each RMII tick, `rmii_txd`/`rmii_tx_en` then take `rmii_rxd`/`rmii_crs_dv`, and `mac_txd`/`mac_tx_en` are ignored.
- R10: If both `cfg_rmii_echo` and `cfg_rmii_loop` are set, echo is ignored, and `cfg_conflict` goes high one cycle later.
- R11: If a diagnostic request fails its qualifying conditions, the bridge runs the normal transmit and receive paths.
- R12: With RMII off, `mac_rxd`/`mac_rx_dv`/`mac_crs` take `mii_rxd`/`mii_rx_dv`/`mii_crs` and `mii_txd`/`mii_tx_en` take `mac_txd`/`mac_tx_en`, each one cycle later, and the RMII transmit outputs are zero. With RMII on, `mii_txd`/`mii_tx_en` are zero.
- R13: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mii_mode | input | 1 | Requests RMII operation |
| cfg_pin_sel | input | 2 | Pin-function select bits; both must be 1 for RMII |
| cfg_speed_10 | input | 1 | 1 = 10 Mbps, 0 = 100 Mbps |
| cfg_rmii_loop | input | 1 | Loopback request |
| cfg_rmii_echo | input | 1 | Echo request |
| cfg_mac_loop | input | 1 | MAC-level loopback is active (disqualifies both paths) |
| cfg_full_duplex | input | 1 | Full duplex enabled (needed for loopback) |
| mac_txd | input | 4 | MAC transmit nibble |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_rxd | output | 4 | Receive nibble to the MAC |
| mac_rx_dv | output | 1 | Receive data valid to the MAC |
| mac_crs | output | 1 | Carrier sense to the MAC |
| mac_clk_en | output | 1 | MAC nibble-rate clock enable |
| rmii_txd | output | 2 | RMII transmit dibit |
| rmii_tx_en | output | 1 | RMII transmit enable |
| rmii_rxd | input | 2 | RMII receive dibit |
| rmii_crs_dv | input | 1 | RMII carrier sense / data valid |
| rmii_smp_en | output | 1 | RMII dibit-rate sampling enable |
| mii_txd | output | 4 | MII PHY transmit nibble (pass-through) |
| mii_tx_en | output | 1 | MII PHY transmit enable (pass-through) |
| mii_rxd | input | 4 | MII PHY receive nibble |
| mii_rx_dv | input | 1 | MII PHY receive data valid |
| mii_crs | input | 1 | MII PHY carrier sense |
| rmii_active | output | 1 | Effective RMII enable status |
| cfg_conflict | output | 1 | Echo and loopback were both requested |

## Verification
The assertions check the following on every cycle:
- the registered RMII status and the conflict flag;
- the continuous sampling enable at 100 Mbps, and the single-cycle width of MAC enables;
- the quiet RMII transmit pins outside RMII mode, and the quiet MII transmit pins inside it;
- the one-tick echo of receive dibits onto the transmit pins.

Other behaviour shows up only in the bench's scenarios against its reference model:
- the dibit order of serialisation and of reassembly;
- the arming rule after reset while carrier/data-valid is held high;
- the 10 Mbps pulse spacing;
- the loopback return path;
- the fallback to normal paths when a diagnostic request fails its conditions.

// File: rtl/rmii_bridge_pkg.sv
package rmii_bridge_pkg;
  localparam int NIB_W = 4;
  localparam int DIB_W = 2;

  typedef logic [DIB_W-1:0] dibit_t;
  typedef logic [NIB_W-1:0] nibble_t;

  typedef enum logic [1:0] {
    PATH_NORMAL = 2'd0,
    PATH_LOOP   = 2'd1,
    PATH_ECHO   = 2'd2
  } path_e;
endpackage

// File: rtl/rmii_clk_div.sv
module rmii_clk_div #(
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_10,
  output logic tick,
  output logic dibit_hi,
  output logic rmii_en_q,
  output logic mac_en_q
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          ph_q, ph_d;

  always_comb begin
    lim      = speed_10 ? SLOW_LIM : FAST_LIM;
    tick     = (cnt_q >= lim);
    cnt_d    = tick ? '0 : cnt_q + 1'b1;
    ph_d     = tick ? ~ph_q : ph_q;
    dibit_hi = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ph_q      <= 1'b0;
      rmii_en_q <= 1'b0;
      mac_en_q  <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      ph_q      <= ph_d;
      rmii_en_q <= tick;
      mac_en_q  <= tick & ph_q;
    end
  end
endmodule

// File: rtl/rmii_tx_ser.sv
module rmii_tx_ser
  import rmii_bridge_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    dibit_hi,
  input  logic    rmii_on,
  input  logic    echo_on,
  input  nibble_t mac_txd,
  input  logic    mac_tx_en,
  input  dibit_t  phy_rxd,
  input  logic    phy_crs_dv,
  output dibit_t  txd_q,
  output logic    tx_en_q
);
  dibit_t hold_q, hold_d, txd_d;
  logic   tx_en_d;

  always_comb begin
    txd_d   = txd_q;
    tx_en_d = tx_en_q;
    hold_d  = hold_q;
    if (!rmii_on) begin
      txd_d   = '0;
      tx_en_d = 1'b0;
    end else if (tick) begin
      if (echo_on) begin
        txd_d   = phy_rxd;
        tx_en_d = phy_crs_dv;
      end else if (!dibit_hi) begin
        txd_d   = mac_txd[DIB_W-1:0];
        hold_d  = mac_txd[NIB_W-1:DIB_W];
        tx_en_d = mac_tx_en;
      end else begin
        txd_d   = hold_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= '0;
      tx_en_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      txd_q   <= txd_d;
      tx_en_q <= tx_en_d;
      hold_q  <= hold_d;
    end
  end
endmodule

// File: rtl/rmii_rx_asm.sv
module rmii_rx_asm
  import rmii_bridge_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    rmii_on,
  input  logic    loop_on,
  input  dibit_t  phy_rxd,
  input  logic    phy_crs_dv,
  input  dibit_t  lb_txd,
  input  logic    lb_tx_en,
  input  nibble_t mii_rxd,
  input  logic    mii_rx_dv,
  input  logic    mii_crs,
  output nibble_t rxd_q,
  output logic    rx_dv_q,
  output logic    crs_q
);
  dibit_t  src_d, low_q, low_d;
  logic    src_c;
  logic    armed_q, armed_d, align_q, align_d;
  nibble_t rxd_d;
  logic    rx_dv_d, crs_d;

  always_comb begin
    src_d   = loop_on ? lb_txd   : phy_rxd;
    src_c   = loop_on ? lb_tx_en : phy_crs_dv;
    rxd_d   = rxd_q;
    rx_dv_d = rx_dv_q;
    crs_d   = crs_q;
    low_d   = low_q;
    armed_d = armed_q;
    align_d = align_q;
    if (!rmii_on) begin
      armed_d = 1'b0;
      align_d = 1'b0;
      rxd_d   = mii_rxd;
      rx_dv_d = mii_rx_dv;
      crs_d   = mii_crs;
    end else if (tick) begin
      crs_d = src_c;
      if (!src_c) begin
        armed_d = 1'b1;
        align_d = 1'b0;
        rx_dv_d = 1'b0;
      end else if (!armed_q) begin
        rx_dv_d = 1'b0;
      end else if (!align_q) begin
        low_d   = src_d;
        align_d = 1'b1;
      end else begin
        rxd_d   = {src_d, low_q};
        rx_dv_d = 1'b1;
        align_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q   <= '0;
      rx_dv_q <= 1'b0;
      crs_q   <= 1'b0;
      low_q   <= '0;
      armed_q <= 1'b0;
      align_q <= 1'b0;
    end else begin
      rxd_q   <= rxd_d;
      rx_dv_q <= rx_dv_d;
      crs_q   <= crs_d;
      low_q   <= low_d;
      armed_q <= armed_d;
      align_q <= align_d;
    end
  end
endmodule

// File: rtl/rmii_bridge.sv
module rmii_bridge
  import rmii_bridge_pkg::*;
#(
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_mii_mode,
  input  logic [1:0] cfg_pin_sel,
  input  logic       cfg_speed_10,
  input  logic       cfg_rmii_loop,
  input  logic       cfg_rmii_echo,
  input  logic       cfg_mac_loop,
  input  logic       cfg_full_duplex,
  input  logic [3:0] mac_txd,
  input  logic       mac_tx_en,
  output logic [3:0] mac_rxd,
  output logic       mac_rx_dv,
  output logic       mac_crs,
  output logic       mac_clk_en,
  output logic [1:0] rmii_txd,
  output logic       rmii_tx_en,
  input  logic [1:0] rmii_rxd,
  input  logic       rmii_crs_dv,
  output logic       rmii_smp_en,
  output logic [3:0] mii_txd,
  output logic       mii_tx_en,
  input  logic [3:0] mii_rxd,
  input  logic       mii_rx_dv,
  input  logic       mii_crs,
  output logic       rmii_active,
  output logic       cfg_conflict
);
  logic  rmii_on, tick, dibit_hi;
  path_e path;
  logic  act_d, conf_d;
  nibble_t mii_txd_d;
  logic    mii_tx_en_d;

  always_comb begin
    rmii_on = cfg_mii_mode & (&cfg_pin_sel);
    if (rmii_on && cfg_rmii_loop && !cfg_mac_loop && cfg_full_duplex)
      path = PATH_LOOP;
    else if (rmii_on && cfg_rmii_echo && !cfg_rmii_loop && !cfg_mac_loop)
      path = PATH_ECHO;
    else
      path = PATH_NORMAL;
    act_d       = rmii_on;
    conf_d      = cfg_rmii_echo & cfg_rmii_loop;
    mii_txd_d   = rmii_on ? '0 : mac_txd;
    mii_tx_en_d = rmii_on ? 1'b0 : mac_tx_en;
  end

  rmii_clk_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .speed_10(cfg_speed_10),
    .tick(tick), .dibit_hi(dibit_hi),
    .rmii_en_q(rmii_smp_en), .mac_en_q(mac_clk_en)
  );

  rmii_tx_ser tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dibit_hi(dibit_hi),
    .rmii_on(rmii_on), .echo_on(path == PATH_ECHO),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en),
    .phy_rxd(rmii_rxd), .phy_crs_dv(rmii_crs_dv),
    .txd_q(rmii_txd), .tx_en_q(rmii_tx_en)
  );

  rmii_rx_asm rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .rmii_on(rmii_on), .loop_on(path == PATH_LOOP),
    .phy_rxd(rmii_rxd), .phy_crs_dv(rmii_crs_dv),
    .lb_txd(rmii_txd), .lb_tx_en(rmii_tx_en),
    .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_crs(mii_crs),
    .rxd_q(mac_rxd), .rx_dv_q(mac_rx_dv), .crs_q(mac_crs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmii_active  <= 1'b0;
      cfg_conflict <= 1'b0;
      mii_txd      <= '0;
      mii_tx_en    <= 1'b0;
    end else begin
      rmii_active  <= act_d;
      cfg_conflict <= conf_d;
      mii_txd      <= mii_txd_d;
      mii_tx_en    <= mii_tx_en_d;
    end
  end
endmodule

// File: rtl/rmii_bridge_chk.sv
module rmii_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_mii_mode,
  input logic [1:0] cfg_pin_sel,
  input logic       cfg_speed_10,
  input logic       cfg_rmii_loop,
  input logic       cfg_rmii_echo,
  input logic       cfg_mac_loop,
  input logic       mac_clk_en,
  input logic       rmii_smp_en,
  input logic [1:0] rmii_txd,
  input logic       rmii_tx_en,
  input logic [1:0] rmii_rxd,
  input logic       rmii_crs_dv,
  input logic       mii_tx_en,
  input logic       rmii_active,
  input logic       cfg_conflict
);
  logic started;
  logic on_in, echo_in;

  always_comb begin
    on_in   = cfg_mii_mode & cfg_pin_sel[1] & cfg_pin_sel[0];
    echo_in = on_in & cfg_rmii_echo & ~cfg_rmii_loop & ~cfg_mac_loop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R1
  active_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (rmii_active == $past(on_in)));

  // R10
  conflict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (cfg_conflict == $past(cfg_rmii_echo && cfg_rmii_loop)));

  // R2
  fast_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(!cfg_speed_10)) |-> rmii_smp_en);

  // R3
  mac_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_clk_en |=> !mac_clk_en);

  // R3
  mac_inside_rmii_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_clk_en |-> rmii_smp_en);

  // R12
  rmii_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(!on_in)) |-> (!rmii_tx_en && rmii_txd == 2'b00));

  // R12
  mii_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(on_in)) |-> !mii_tx_en);

  // R9
  echo_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rmii_smp_en && $past(echo_in)) |->
      (rmii_txd == $past(rmii_rxd) && rmii_tx_en == $past(rmii_crs_dv)));
endmodule

bind rmii_bridge rmii_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mii_mode(cfg_mii_mode), .cfg_pin_sel(cfg_pin_sel),
  .cfg_speed_10(cfg_speed_10), .cfg_rmii_loop(cfg_rmii_loop), .cfg_rmii_echo(cfg_rmii_echo),
  .cfg_mac_loop(cfg_mac_loop), .mac_clk_en(mac_clk_en), .rmii_smp_en(rmii_smp_en),
  .rmii_txd(rmii_txd), .rmii_tx_en(rmii_tx_en), .rmii_rxd(rmii_rxd),
  .rmii_crs_dv(rmii_crs_dv), .mii_tx_en(mii_tx_en), .rmii_active(rmii_active),
  .cfg_conflict(cfg_conflict)
);

// File: tb/rmii_bridge_tb_top.sv
`timescale 1ns/1ps
module rmii_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mii_mode = 0, cfg_speed_10 = 0, cfg_rmii_loop = 0, cfg_rmii_echo = 0;
  logic cfg_mac_loop = 0, cfg_full_duplex = 0;
  logic [1:0] cfg_pin_sel = 0;
  logic [3:0] mac_txd = 0, mii_rxd = 0;
  logic mac_tx_en = 0, rmii_crs_dv = 0, mii_rx_dv = 0, mii_crs = 0;
  logic [1:0] rmii_rxd = 0;
  logic [3:0] mac_rxd, mii_txd;
  logic mac_rx_dv, mac_crs, mac_clk_en, rmii_tx_en, rmii_smp_en, mii_tx_en;
  logic rmii_active, cfg_conflict;
  logic [1:0] rmii_txd;

  int checks = 0, fails = 0;
  bit cmp_en = 0;
  int crs_force = 0;  // 0 random, 1 held high, 2 held low

  rmii_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mii_mode(cfg_mii_mode), .cfg_pin_sel(cfg_pin_sel),
    .cfg_speed_10(cfg_speed_10), .cfg_rmii_loop(cfg_rmii_loop), .cfg_rmii_echo(cfg_rmii_echo),
    .cfg_mac_loop(cfg_mac_loop), .cfg_full_duplex(cfg_full_duplex),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv),
    .mac_crs(mac_crs), .mac_clk_en(mac_clk_en), .rmii_txd(rmii_txd), .rmii_tx_en(rmii_tx_en),
    .rmii_rxd(rmii_rxd), .rmii_crs_dv(rmii_crs_dv), .rmii_smp_en(rmii_smp_en),
    .mii_txd(mii_txd), .mii_tx_en(mii_tx_en), .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv),
    .mii_crs(mii_crs), .rmii_active(rmii_active), .cfg_conflict(cfg_conflict)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_rc;
  bit m_ph, m_txen, m_arm, m_aln, m_rxdv, m_crs, m_smp, m_mac, m_act, m_conf, m_miitxen;
  bit [1:0] m_txd, m_hold, m_low;
  bit [3:0] m_rxd, m_miitxd;
  bit m_on, m_lp, m_ec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rc = 0; m_ph = 0; m_txen = 0; m_arm = 0; m_aln = 0; m_rxdv = 0; m_crs = 0;
      m_smp = 0; m_mac = 0; m_act = 0; m_conf = 0; m_miitxen = 0;
      m_txd = 0; m_hold = 0; m_low = 0; m_rxd = 0; m_miitxd = 0;
    end else begin
      bit tk, c;
      bit [1:0] d;
      m_on = cfg_mii_mode && cfg_pin_sel == 2'b11;
      m_lp = m_on && cfg_rmii_loop && !cfg_mac_loop && cfg_full_duplex;
      m_ec = m_on && cfg_rmii_echo && !cfg_rmii_loop && !cfg_mac_loop;
      tk = (m_rc >= (cfg_speed_10 ? 9 : 0));
      if (!m_on) begin
        m_arm = 0; m_aln = 0; m_rxd = mii_rxd; m_rxdv = mii_rx_dv; m_crs = mii_crs;
      end else if (tk) begin
        d = m_lp ? m_txd : rmii_rxd;
        c = m_lp ? m_txen : rmii_crs_dv;
        m_crs = c;
        if (!c) begin m_arm = 1; m_aln = 0; m_rxdv = 0; end
        else if (!m_arm) m_rxdv = 0;
        else if (!m_aln) begin m_low = d; m_aln = 1; end
        else begin m_rxd = {d, m_low}; m_rxdv = 1; m_aln = 0; end
      end
      if (!m_on) begin m_txd = 0; m_txen = 0; end
      else if (tk) begin
        if (m_ec) begin m_txd = rmii_rxd; m_txen = rmii_crs_dv; end
        else if (!m_ph) begin m_txd = mac_txd[1:0]; m_hold = mac_txd[3:2]; m_txen = mac_tx_en; end
        else m_txd = m_hold;
      end
      m_smp = tk;
      m_mac = tk && m_ph;
      if (tk) begin m_rc = 0; m_ph = !m_ph; end else m_rc++;
      m_act = m_on;
      m_conf = cfg_rmii_echo && cfg_rmii_loop;
      m_miitxd = m_on ? 4'h0 : mac_txd;
      m_miitxen = m_on ? 1'b0 : mac_tx_en;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      string ten, txt, rxt;
      ten = cfg_speed_10 ? "R3" : "R2";
      txt = !m_on ? "R12" : (m_ec ? "R9" : ((cfg_rmii_echo || cfg_rmii_loop) ? "R11" : "R4"));
      rxt = !m_on ? "R12" : (m_lp ? "R8" : ((cfg_rmii_echo || cfg_rmii_loop) ? "R11" : "R5"));
      check({ten, " rmii_smp_en"}, rmii_smp_en, m_smp);
      check({ten, " mac_clk_en"}, mac_clk_en, m_mac);
      check({txt, " rmii_txd"}, rmii_txd, m_txd);
      check({txt, " rmii_tx_en"}, rmii_tx_en, m_txen);
      check({rxt, " mac_rxd"}, mac_rxd, m_rxd);
      check({rxt, " mac_rx_dv"}, mac_rx_dv, m_rxdv);
      check("R7 mac_crs", mac_crs, m_crs);
      check("R12 mii_txd", mii_txd, m_miitxd);
      check("R12 mii_tx_en", mii_tx_en, m_miitxen);
      check("R1 rmii_active", rmii_active, m_act);
      check("R10 cfg_conflict", cfg_conflict, m_conf);
    end
  end

  // background stimulus, applied shortly after each falling edge
  always begin
    @(negedge clk);
    #1;
    mac_txd <= 4'($urandom);
    rmii_rxd <= 2'($urandom);
    mii_rxd <= 4'($urandom);
    mii_rx_dv <= 1'($urandom);
    mii_crs <= 1'($urandom);
    if (($urandom % 24) == 0) mac_tx_en <= ~mac_tx_en;
    if (crs_force == 1) rmii_crs_dv <= 1'b1;
    else if (crs_force == 2) rmii_crs_dv <= 1'b0;
    else if (($urandom % 40) == 0) rmii_crs_dv <= ~rmii_crs_dv;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(bit mode, bit [1:0] sel, bit spd, bit lp, bit ec, bit ml, bit fd);
    cfg_mii_mode = mode; cfg_pin_sel = sel; cfg_speed_10 = spd; cfg_rmii_loop = lp;
    cfg_rmii_echo = ec; cfg_mac_loop = ml; cfg_full_duplex = fd;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int cnt;
    #1;
    // R13: outputs zero in reset
    check("R13 reset outputs", {mac_rxd, mac_rx_dv, mac_crs, mac_clk_en, rmii_txd, rmii_tx_en,
          rmii_smp_en, mii_txd, mii_tx_en, rmii_active, cfg_conflict}, 0);
    set_cfg(1, 2'b11, 0, 0, 0, 0, 1);
    step(3);
    rst_n = 1'b1;
    cmp_en = 1;
    // normal 100 Mbps traffic
    step(800);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin step(1); cnt += mac_clk_en; end
    check("R2 mac_clk_en pulses in 200 cycles", cnt, 100);
    // 10 Mbps
    set_cfg(1, 2'b11, 1, 0, 0, 0, 1);
    step(100);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin step(1); cnt += mac_clk_en; end
    check("R3 mac_clk_en pulses in 200 cycles", cnt, 10);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin step(1); cnt += rmii_smp_en; end
    check("R3 rmii_smp_en pulses in 200 cycles", cnt, 20);
    step(2000);
    // loopback, 100 Mbps, full duplex
    set_cfg(1, 2'b11, 0, 1, 0, 0, 1);
    step(1500);
    // loopback without full duplex falls back (R11)
    set_cfg(1, 2'b11, 0, 1, 0, 0, 0);
    step(600);
    // echo
    set_cfg(1, 2'b11, 0, 0, 1, 0, 1);
    step(1000);
    // echo with MAC loopback disqualified (R11)
    set_cfg(1, 2'b11, 0, 0, 1, 1, 1);
    step(600);
    // both requested: loopback wins (R10)
    set_cfg(1, 2'b11, 0, 1, 1, 0, 1);
    step(2);
    check("R10 conflict flag raised", cfg_conflict, 1);
    step(1000);
    // pass-through cases (R12, R1)
    set_cfg(1, 2'b01, 0, 0, 0, 0, 1);
    step(2);
    check("R1 active low with one select bit", rmii_active, 0);
    step(300);
    set_cfg(0, 2'b11, 1, 0, 0, 0, 1);
    step(300);
    // R6: reset with carrier held high, no data until a low sample
    set_cfg(1, 2'b11, 0, 0, 0, 0, 1);
    crs_force = 1;
    step(20);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin step(1); cnt += mac_rx_dv; end
    check("R6 no valid data before carrier low", cnt, 0);
    crs_force = 2;
    step(4);
    crs_force = 1;
    step(10);
    check("R6 valid after fresh carrier", mac_rx_dv, 1);
    crs_force = 0;
    step(1500);
    // re-entry into RMII after pass-through with carrier high (R6)
    crs_force = 1;
    set_cfg(0, 2'b11, 0, 0, 0, 0, 1);
    step(5);
    set_cfg(1, 2'b11, 0, 0, 0, 0, 1);
    step(2);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin step(1); cnt += mac_rx_dv; end
    check("R6 no valid data after mode re-entry", cnt, 0);
    crs_force = 0;
    step(500);
    summary();
  end
endmodule